// File: doc/BRIEF.md
# Delayed Branch Next-PC Unit

This unit sits in the execute stage of a 32-bit processor whose instructions are 16-bit halfwords. For every instruction that retires, it produces the next program counter. When the retiring instruction is a delayed branch, the unit works out two things: whether the branch is taken, and where it goes. It stores that decision in a register. It then lets exactly one more instruction, the delay slot, retire at the sequential address. After that instruction retires, it redirects to the stored target. A call also asks for the return pointer to be written with the address that follows the delay slot.

The surrounding pipeline supplies several inputs: the instruction word, its PC, the N/Z/V/C flags, the value of the general register named by the low nibble of the instruction, and the current return pointer. The pipeline also marks the instruction as multi-cycle where that applies. The unit never changes any flag. It raises an error output when the delay slot holds an instruction that is not allowed there.

The sequencer has two states, and all transitions happen on a clock edge where `instr_valid` is high:
- `S_RUN` is normal flow. A delayed branch moves it to `S_SLOT` (transition *branch accept*). Any other instruction keeps it in `S_RUN`.
- `S_SLOT` means the delay slot is pending. The retiring slot instruction returns it to `S_RUN` (transition *slot retire*). A cycle without `instr_valid` holds the state (transition *stall hold*).

Top module: `dbr_next_pc`

## Requirements
- R1: After reset, `in_slot`, `illegal` and `rp_we` are 0. While `instr_valid` is 0, `next_pc` equals `pc`.
- R2: In normal state, a retiring delayed branch gives `next_pc = pc + 2`, and `in_slot` is 1 from the next cycle on.
- R3: A conditional branch has `instr[15:12] = 4'hF`. Its condition code `instr[11:8]` is tested against the flags, where `nzvc[3]`=N, `[2]`=Z, `[1]`=V and `[0]`=C. Codes 0..15 mean: always, never, Z, !Z, C, !C, N, !N, V, !V, V^N, !(V^N), (V^N)|Z, !((V^N)|Z), C|Z, !(C|Z).
- R4: The target of a conditional branch is `pc + 2 + 2*sext(instr[7:0])`.
- R5: An immediate call (`instr[15:11] = 5'b11011`) targets `pc + 2 + 2*sext(instr[10:0])`. It drives `rp_we` = 1 with `rp_wdata = pc + 4` in the cycle it retires.
- R6: With `instr[15:8] = 8'h9F`, sub-op `instr[7:4]` = 0 is a jump to `reg_val`. Sub-op 1 is a call to `reg_val`, which also writes `pc + 4` to the return pointer. Sub-ops 3..15 are not branches.
- R7: Sub-op 2 under `8'h9F` is a return whose target is `rp_val`.
- R8: When the delay-slot instruction retires, `next_pc` is the stored target if the branch was taken, otherwise `pc + 2`. `in_slot` falls to 0 in the next cycle.
- R9: In the delay slot, `illegal` is 1 when the retiring instruction has `multi_cycle` set or is itself a delayed branch. A branch in the slot is not decoded: it writes no return pointer, and the stored redirect still applies.
- R10: A cycle without `instr_valid` in the delay slot keeps `in_slot` and the stored target unchanged.
- R11: In normal state, any other instruction gives `next_pc = pc + 2` and `rp_we = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction retires this cycle |
| instr | input | 16 | Retiring instruction word |
| pc | input | 32 | Address of the retiring instruction |
| nzvc | input | 4 | Flags N, Z, V, C (bit 3 down to bit 0) |
| reg_val | input | 32 | General register selected by instr[3:0] |
| rp_val | input | 32 | Current return pointer |
| multi_cycle | input | 1 | Retiring instruction needs more than one cycle |
| next_pc | output | 32 | PC of the next instruction |
| rp_we | output | 1 | Return pointer write enable |
| rp_wdata | output | 32 | Return pointer write data |
| in_slot | output | 1 | Delay slot pending |
| illegal | output | 1 | Illegal instruction in the delay slot |

## Verification
The hardest situation to reach is a delay slot that holds another delayed branch, with a stall cycle in between. Reaching it takes three consecutive events: first a branch, then a cycle without `instr_valid`, then a second branch. The random stimulus favours branch encodings and drops `instr_valid` about one cycle in seven, so such runs occur many times. Directed sequences also build this case explicitly, and they check that the first branch's redirect survives while the second branch's call leaves the return pointer alone.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    typedef enum logic {
        S_RUN  = 1'b0,
        S_SLOT = 1'b1
    } dbr_state_e;

    // Positive sense of each condition pair; odd codes invert it.
    function automatic logic cond_base(input logic [2:0] pair, input logic [3:0] f);
        logic n, z, v, c;
        n = f[3];
        z = f[2];
        v = f[1];
        c = f[0];
        unique case (pair)
            3'd0:    cond_base = 1'b1;
            3'd1:    cond_base = z;
            3'd2:    cond_base = c;
            3'd3:    cond_base = n;
            3'd4:    cond_base = v;
            3'd5:    cond_base = v ^ n;
            3'd6:    cond_base = (v ^ n) | z;
            default: cond_base = c | z;
        endcase
    endfunction

endpackage

// File: rtl/dbr_cond_eval.sv
module dbr_cond_eval #(
    parameter int PAIRS = 8
) (
    input  logic [3:0] nzvc,
    input  logic [3:0] code,
    output logic       pass
);
    localparam int SEL_W = $clog2(PAIRS);

    logic [PAIRS-1:0] base;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign base[g] = dbr_pkg::cond_base(SEL_W'(g), nzvc);
    end

    assign pass = base[code[3:1]] ^ code[0];

endmodule

// File: rtl/dbr_decode.sv
module dbr_decode #(
    parameter int XLEN = 32,
    parameter int ILEN = 16
) (
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] reg_val,
    input  logic [XLEN-1:0] rp_val,
    output logic            is_br,
    output logic            is_cond,
    output logic            link,
    output logic [XLEN-1:0] target
);
    localparam int REL8_W  = 8;
    localparam int REL11_W = 11;

    logic [XLEN-1:0] seq_pc, off8, off11;
    logic            hit_cond, hit_calli, hit_ind;
    logic [3:0]      sub_op;

    assign seq_pc = pc + XLEN'(2);
    assign off8   = {{(XLEN-REL8_W-1){instr[REL8_W-1]}}, instr[REL8_W-1:0], 1'b0};
    assign off11  = {{(XLEN-REL11_W-1){instr[REL11_W-1]}}, instr[REL11_W-1:0], 1'b0};
    assign sub_op = instr[7:4];

    assign hit_cond  = (instr[15:12] == 4'hF);
    assign hit_calli = (instr[15:11] == 5'b11011);
    assign hit_ind   = (instr[15:8] == 8'h9F) && (sub_op <= 4'd2);

    always_comb begin
        is_br   = hit_cond | hit_calli | hit_ind;
        is_cond = hit_cond;
        link    = 1'b0;
        target  = seq_pc;
        if (hit_cond) begin
            target = seq_pc + off8;
        end else if (hit_calli) begin
            target = seq_pc + off11;
            link   = 1'b1;
        end else if (hit_ind) begin
            unique case (sub_op)
                4'd0:    target = reg_val;
                4'd1: begin
                    target = reg_val;
                    link   = 1'b1;
                end
                default: target = rp_val;
            endcase
        end
    end

    always_comb begin
        assert (!(hit_cond && hit_calli) && !(hit_cond && hit_ind) && !(hit_calli && hit_ind))
            else $error("AST_ONE_CLASS: overlapping branch classes"); // R3
    end

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
    import dbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic            is_br,
    input  logic            taken,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] pc,
    input  logic            multi_cycle,
    output logic [XLEN-1:0] next_pc,
    output logic            accept,
    output logic            in_slot,
    output logic            illegal
);
    dbr_state_e      state_q, state_d;
    logic [XLEN-1:0] pend_tgt_q;
    logic            pend_take_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  if (instr_valid && is_br) state_d = S_SLOT;
            S_SLOT: if (instr_valid)          state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tgt_q  <= '0;
            pend_take_q <= 1'b0;
        end else if (state_q == S_RUN && instr_valid && is_br) begin
            pend_tgt_q  <= target;
            pend_take_q <= taken;
        end
    end

    always_comb begin
        next_pc = pc;
        accept  = 1'b0;
        illegal = 1'b0;
        in_slot = (state_q == S_SLOT);
        unique case (state_q)
            S_RUN: if (instr_valid) begin
                next_pc = pc + XLEN'(2);
                accept  = is_br;
            end
            S_SLOT: if (instr_valid) begin
                next_pc = pend_take_q ? pend_tgt_q : pc + XLEN'(2);
                illegal = multi_cycle | is_br;
            end
            default: ;
        endcase
    end

    AST_SLOT_AFTER_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_slot && instr_valid && is_br) |=> in_slot); // R2
    AST_SLOT_ONE_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && instr_valid) |=> !in_slot); // R8
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && !instr_valid) |=> (in_slot && $stable(pend_tgt_q) && $stable(pend_take_q))); // R10
    AST_ILLEGAL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (in_slot && instr_valid)); // R9

endmodule

// File: rtl/dbr_next_pc.sv
module dbr_next_pc #(
    parameter int XLEN = 32,
    parameter int ILEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    input  logic [3:0]      nzvc,
    input  logic [XLEN-1:0] reg_val,
    input  logic [XLEN-1:0] rp_val,
    input  logic            multi_cycle,
    output logic [XLEN-1:0] next_pc,
    output logic            rp_we,
    output logic [XLEN-1:0] rp_wdata,
    output logic            in_slot,
    output logic            illegal
);
    logic            is_br, is_cond, link, cond_pass, accept;
    logic [XLEN-1:0] target;

    dbr_decode #(.XLEN(XLEN), .ILEN(ILEN)) u_dec (
        .instr   (instr),
        .pc      (pc),
        .reg_val (reg_val),
        .rp_val  (rp_val),
        .is_br   (is_br),
        .is_cond (is_cond),
        .link    (link),
        .target  (target)
    );

    dbr_cond_eval #(.PAIRS(8)) u_cond (
        .nzvc (nzvc),
        .code (instr[11:8]),
        .pass (cond_pass)
    );

    dbr_seq #(.XLEN(XLEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .is_br       (is_br),
        .taken       (is_cond ? cond_pass : 1'b1),
        .target      (target),
        .pc          (pc),
        .multi_cycle (multi_cycle),
        .next_pc     (next_pc),
        .accept      (accept),
        .in_slot     (in_slot),
        .illegal     (illegal)
    );

    assign rp_we    = accept & link;
    assign rp_wdata = pc + XLEN'(4);

    AST_NO_LINK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |-> !rp_we); // R9
    AST_LINK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rp_we |-> instr_valid); // R5
    AST_STALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (next_pc == pc)); // R1

endmodule

// File: tb/dbr_next_pc_tb_top.sv
module dbr_next_pc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] pc = '0, reg_val = '0, rp_val = '0;
    logic [3:0]  nzvc = '0;
    logic        multi_cycle = 1'b0;
    logic [31:0] next_pc, rp_wdata;
    logic        rp_we, in_slot, illegal;

    int errors = 0;
    int checks = 0;

    logic        m_slot = 1'b0;
    logic        m_take = 1'b0;
    logic [31:0] m_tgt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbr_next_pc dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc(pc), .nzvc(nzvc), .reg_val(reg_val), .rp_val(rp_val),
        .multi_cycle(multi_cycle), .next_pc(next_pc), .rp_we(rp_we),
        .rp_wdata(rp_wdata), .in_slot(in_slot), .illegal(illegal)
    );

    function automatic bit f_cond(input logic [3:0] code, input logic [3:0] f);
        bit n = f[3], z = f[2], v = f[1], c = f[0];
        case (code)
            4'd0:  return 1;          4'd1:  return 0;
            4'd2:  return z;          4'd3:  return !z;
            4'd4:  return c;          4'd5:  return !c;
            4'd6:  return n;          4'd7:  return !n;
            4'd8:  return v;          4'd9:  return !v;
            4'd10: return v ^ n;      4'd11: return !(v ^ n);
            4'd12: return (v ^ n) | z; 4'd13: return !((v ^ n) | z);
            4'd14: return c | z;      default: return !(c | z);
        endcase
    endfunction

    // kind: 0 none, 1 cond, 2 call imm, 3 jmp reg, 4 call reg, 5 ret
    function automatic int f_kind(input logic [15:0] w);
        if (w[15:12] == 4'hF) return 1;
        if (w[15:11] == 5'b11011) return 2;
        if (w[15:8] == 8'h9F && w[7:4] == 4'd0) return 3;
        if (w[15:8] == 8'h9F && w[7:4] == 4'd1) return 4;
        if (w[15:8] == 8'h9F && w[7:4] == 4'd2) return 5;
        return 0;
    endfunction

    function automatic logic [31:0] f_target(input logic [15:0] w, input logic [31:0] p,
                                             input logic [31:0] rv, input logic [31:0] rpv);
        case (f_kind(w))
            1: return p + 32'd2 + 32'($signed(w[7:0])) * 2;
            2: return p + 32'd2 + 32'($signed(w[10:0])) * 2;
            3, 4: return rv;
            5: return rpv;
            default: return p + 32'd2;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at negedge, check combinational outputs 1 time unit later, then advance the model.
    task automatic step(input logic v, input logic [15:0] w, input logic [31:0] p,
                        input logic [3:0] f, input logic [31:0] rv, input logic [31:0] rpv,
                        input logic mc, input string req);
        int k;
        logic [31:0] e_pc;
        logic e_we, e_ill;
        @(negedge clk);
        instr_valid = v; instr = w; pc = p; nzvc = f;
        reg_val = rv; rp_val = rpv; multi_cycle = mc;
        #1;
        k = f_kind(w);
        e_pc = !v ? p : (!m_slot ? p + 32'd2 : (m_take ? m_tgt : p + 32'd2));
        e_we = v && !m_slot && (k == 2 || k == 4);
        e_ill = v && m_slot && (mc || k != 0);
        chk(req, "next_pc", next_pc, e_pc);
        chk(req, "in_slot", 32'(in_slot), 32'(m_slot));
        chk(req, "illegal", 32'(illegal), 32'(e_ill));
        chk(req, "rp_we", 32'(rp_we), 32'(e_we));
        if (e_we) chk(req, "rp_wdata", rp_wdata, p + 32'd4);
        if (v) begin
            if (!m_slot && k != 0) begin
                m_slot = 1'b1;
                m_tgt  = f_target(w, p, rv, rpv);
                m_take = (k == 1) ? f_cond(w[11:8], f) : 1'b1;
            end else if (m_slot) begin
                m_slot = 1'b0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [31:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset in_slot", 32'(in_slot), 0);
        chk("R1", "reset illegal", 32'(illegal), 0);
        chk("R1", "reset rp_we", 32'(rp_we), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R4 R8: always-branch, backwards offset, taken
        step(1, 16'hF0FE, 32'h0000_1000, 4'h0, 0, 0, 0, "R2_R4");
        step(1, 16'h1234, 32'h0000_1002, 4'h0, 0, 0, 0, "R8");
        // R3: never branch, slot falls through
        step(1, 16'hF17F, 32'h0000_2000, 4'hF, 0, 0, 0, "R3");
        step(1, 16'h0000, 32'h0000_2002, 4'h0, 0, 0, 0, "R3_R8");
        // R3: every condition code against two flag sets
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 2; s++) begin
                step(1, {4'hF, 4'(c), 8'h10}, 32'h3000 + 32'(c*64), s ? 4'b1010 : 4'b0101, 0, 0, 0, "R3");
                step(1, 16'h0100, 32'h3002 + 32'(c*64), 4'h0, 0, 0, 0, "R3");
            end
        end
        // R5: immediate call, negative offset
        step(1, {5'b11011, 11'h400}, 32'h0001_0000, 4'h0, 0, 0, 0, "R5");
        step(1, 16'h0000, 32'h0001_0002, 4'h0, 0, 0, 0, "R5");
        // R6: jump and call through register, sub-op 3 is not a branch
        step(1, 16'h9F05, 32'h4000, 4'h0, 32'hABCD_0010, 0, 0, "R6");
        step(1, 16'h0000, 32'h4002, 4'h0, 0, 0, 0, "R6");
        step(1, 16'h9F1A, 32'h5000, 4'h0, 32'h0000_8888, 0, 0, "R6");
        step(1, 16'h0000, 32'h5002, 4'h0, 0, 0, 0, "R6");
        step(1, 16'h9F30, 32'h5100, 4'h0, 32'h0000_7777, 0, 0, "R6_R11");
        // R7: return
        step(1, 16'h9F20, 32'h6000, 4'h0, 0, 32'h0000_4444, 0, "R7");
        step(1, 16'h0000, 32'h6002, 4'h0, 0, 0, 0, "R7");
        // R9 R10: stall in slot, then a call in the slot
        step(1, 16'hF040, 32'h7000, 4'h0, 0, 0, 0, "R10");
        step(0, 16'hFFFF, 32'h7002, 4'h0, 0, 0, 0, "R10");
        step(0, 16'h0000, 32'h7002, 4'h0, 0, 0, 0, "R10");
        step(1, 16'h9F10, 32'h7002, 4'h0, 32'h1111_0000, 0, 0, "R9");
        step(1, 16'h0000, 32'h7082, 4'h0, 0, 0, 0, "R11");
        // R9: multi-cycle in slot
        step(1, 16'hF102, 32'h8000, 4'h0, 0, 0, 0, "R9");
        step(1, 16'h0000, 32'h8002, 4'h0, 0, 0, 1, "R9");
        // R11: plain instruction with multi flag in normal state
        step(1, 16'h1357, 32'h8004, 4'h0, 0, 0, 1, "R11");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 8)
                0, 1, 2: w = {4'hF, 12'($urandom)};
                3:       w = {5'b11011, 11'($urandom)};
                4:       w = {8'h9F, 4'($urandom % 4), 4'($urandom)};
                default: w = 16'($urandom);
            endcase
            p = {$urandom, 1'b0} ;
            step(($urandom % 7) != 0, w, p, 4'($urandom), $urandom, $urandom,
                 ($urandom % 5) == 0, "R2_R8_R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule